// File: doc/BRIEF.md
# Two-Slot Fault Status and Interrupt Register

This block keeps the fault history of a controller that powers two card slots. For each slot it holds an enable register and a status register of three sticky fault flags. A shared status register adds two chip-wide sticky flags, the interrupt mask and the levels of two general-purpose inputs. The fault sources are level signals from analog monitors: rail undervoltage, fast overcurrent, slow overcurrent, slot overtemperature, standby-rail undervoltage and die overtemperature. A flag latches only while its slot, or for the shared flags any slot, is switched on by software.

Software reads and writes the registers through a simple single-cycle register port that stands in for a byte-wide management bus. Reads have no side effects. A fault flag clears when a 1 is written to its bit position. A 0 leaves the flag as it is, so the read value can be echoed back to acknowledge exactly the faults that were seen. A slow overcurrent only counts once it has lasted a programmable filter window, or at once if the slot is also too hot. An active-low interrupt follows the latched flags through a three-state machine, `IRQ_QUIET` (nothing latched), `IRQ_ACTIVE` (latched and unmasked, interrupt low) and `IRQ_HELD` (latched but masked). Its transitions are: QUIET to ACTIVE or HELD when a flag appears, chosen by the mask; ACTIVE and HELD swap when the mask changes; either returns to QUIET when all flags are clear. Each slot's slow-overcurrent filter is a second machine: `FLT_IDLE` (trip absent), `FLT_COUNT` (counting cycles of trip) and `FLT_EXPIRED` (window used up). IDLE moves to COUNT on a trip, COUNT moves to EXPIRED on the last counted cycle, and COUNT and EXPIRED both return to IDLE when the trip goes away.

Top module: `hp_fault_status`

## Requirements
- R1: After reset every enable register and fault flag reads 0, the mask bit reads 1, so the shared register reads 0x08 with both general-purpose inputs low, and `irq_n` is 1.
- R2: Register map: slot s enable at address 2s (bits 1:0 read/write, other bits read 0), slot s status at 2s+1, shared status at 2·NUM_SLOTS; in the shared register bits 5:4 read `gpi[1:0]` and bit 3 is the mask; unused bits and unused addresses read 0.
- R3: A slot flag can latch only on a clock edge where that slot's enable bits 1:0 are not both 0; the shared flags latch only when at least one slot is enabled.
- R4: With the slot enabled, `rail_uv` sets status bit 0 and `oc_fast` sets status bit 2 at the next rising edge.
- R5: A continuous `oc_slow` without `slot_hot` sets status bit 4 on the (FILT_CYCLES+1)-th rising edge that samples it high; a drop restarts the window.
- R6: `oc_slow` together with `slot_hot` sets status bit 4 at the next rising edge.
- R7: `die_hot` sets shared bit 1 and `stby_uv` of an enabled slot sets shared bit 2 at the next rising edge.
- R8: Writing 1 to a flag bit clears it at that edge; a written 0 leaves the flag unchanged.
- R9: When a flag's set condition and a clearing write meet on the same edge, the flag stays 1; a condition still present after a clear sets the flag again.
- R10: `irq_n` goes low one cycle after the edge at which some flag is latched and the mask is 0, and returns high one cycle after the edge at which all flags are clear or the mask is 1.
- R11: Reading any address, any number of times, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rail_uv | input | NUM_SLOTS | Per-slot main rail undervoltage level |
| stby_uv | input | NUM_SLOTS | Per-slot standby rail undervoltage level |
| oc_fast | input | NUM_SLOTS | Per-slot fast overcurrent trip level |
| oc_slow | input | NUM_SLOTS | Per-slot slow overcurrent trip level |
| slot_hot | input | NUM_SLOTS | Per-slot overtemperature level |
| die_hot | input | 1 | Chip-wide overtemperature level |
| gpi | input | 2 | General-purpose input levels |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench first runs directed cases that separate the fault sources: a fault on a disabled slot, which shows that gating works; a slow trip held just up to and just past its window, which finds off-by-one errors in the filter; a slow trip with the hot flag, which shows the bypass; and a clearing write on the same edge as a live condition, which shows that the set wins. It then runs seeded random fault levels, enable values, mask toggles and echo writes, and compares each read and the interrupt every cycle with a reference model. The random mix finds errors in bit positions, in slot crossover and in mask timing that the directed cases can miss.

// File: rtl/hpfs_pkg.sv
package hpfs_pkg;
    localparam int STAT_UV  = 0;
    localparam int STAT_FOC = 2;
    localparam int STAT_SOC = 4;
    localparam int CS_DIE   = 1;
    localparam int CS_STBY  = 2;
    localparam int CS_MASK  = 3;
    localparam int CS_GPI   = 4;

    typedef enum logic [1:0] {
        IRQ_QUIET  = 2'd0,
        IRQ_ACTIVE = 2'd1,
        IRQ_HELD   = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        FLT_IDLE    = 2'd0,
        FLT_COUNT   = 2'd1,
        FLT_EXPIRED = 2'd2
    } filt_state_e;
endpackage

// File: rtl/hpfs_slow_filter.sv
module hpfs_slow_filter
    import hpfs_pkg::*;
#(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_slow,
    output logic expired
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    filt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_IDLE: begin
                if (oc_slow) begin
                    cnt_d   = CNT_W'(1);
                    state_d = (FILT_CYCLES == 1) ? FLT_EXPIRED : FLT_COUNT;
                end
            end
            FLT_COUNT: begin
                if (!oc_slow) begin
                    cnt_d   = '0;
                    state_d = FLT_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == LAST) state_d = FLT_EXPIRED;
                end
            end
            FLT_EXPIRED: begin
                if (!oc_slow) begin
                    cnt_d   = '0;
                    state_d = FLT_IDLE;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = FLT_IDLE;
            end
        endcase
    end

    always_comb expired = (state_q == FLT_EXPIRED);

    // R5
    expire_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(oc_slow));
endmodule

// File: rtl/hpfs_slot_status.sv
module hpfs_slot_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en,
    input  logic       rail_uv,
    input  logic       oc_fast,
    input  logic       oc_slow_ok,
    input  logic [2:0] clr,
    output logic [2:0] fault_q
);
    logic [2:0] set_v;

    always_comb set_v = {oc_slow_ok, oc_fast, rail_uv} & {3{slot_en}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= set_v | (fault_q & ~clr);
    end

    // R3
    no_latch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> ((fault_q & ~$past(fault_q)) == 3'b000));

    // R8
    keep_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_q & ~clr) != 3'b000) |=>
        ((fault_q & $past(fault_q & ~clr)) == $past(fault_q & ~clr)));

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && rail_uv && clr[0]) |=> fault_q[0]);
endmodule

// File: rtl/hpfs_irq_fsm.sv
module hpfs_irq_fsm
    import hpfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_fault,
    input  logic mask,
    output logic irq_n
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (any_fault) state_d = mask ? IRQ_HELD : IRQ_ACTIVE;
            end
            IRQ_ACTIVE: begin
                if (!any_fault) state_d = IRQ_QUIET;
                else if (mask)  state_d = IRQ_HELD;
            end
            IRQ_HELD: begin
                if (!any_fault) state_d = IRQ_QUIET;
                else if (!mask) state_d = IRQ_ACTIVE;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_comb irq_n = (state_q != IRQ_ACTIVE);

    // R10
    irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ($past(any_fault) && !$past(mask)));

    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fault && !mask) |=> !irq_n);
endmodule

// File: rtl/hp_fault_status.sv
module hp_fault_status
    import hpfs_pkg::*;
#(
    parameter int NUM_SLOTS   = 2,
    parameter int FILT_CYCLES = 16,
    parameter int ADDR_W      = $clog2(2 * NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_SLOTS-1:0] rail_uv,
    input  logic [NUM_SLOTS-1:0] stby_uv,
    input  logic [NUM_SLOTS-1:0] oc_fast,
    input  logic [NUM_SLOTS-1:0] oc_slow,
    input  logic [NUM_SLOTS-1:0] slot_hot,
    input  logic                 die_hot,
    input  logic [1:0]           gpi,
    output logic                 irq_n
);
    localparam logic [ADDR_W-1:0] ADDR_CS = ADDR_W'(2 * NUM_SLOTS);

    logic [NUM_SLOTS-1:0][1:0] ctrl_q;
    logic [NUM_SLOTS-1:0][2:0] slot_flt;
    logic [NUM_SLOTS-1:0][2:0] slot_clr;
    logic [NUM_SLOTS-1:0]      slot_en;
    logic [NUM_SLOTS-1:0]      filt_done;
    logic [NUM_SLOTS-1:0]      soc_ok;
    logic [1:0]                cs_flt_q;
    logic [1:0]                cs_set;
    logic [1:0]                cs_clr;
    logic                      mask_q;
    logic                      cs_hit;
    logic                      any_fault;
    logic                      wdata_unused;

    assign wdata_unused = ^reg_wdata[7:5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (reg_wr && reg_addr == ADDR_W'(2 * s)) ctrl_q[s] <= reg_wdata[1:0];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_en[g]  = |ctrl_q[g];
        assign slot_clr[g] = (reg_wr && reg_addr == ADDR_W'(2 * g + 1))
                           ? {reg_wdata[STAT_SOC], reg_wdata[STAT_FOC], reg_wdata[STAT_UV]}
                           : 3'b000;
        assign soc_ok[g]   = oc_slow[g] & (filt_done[g] | slot_hot[g]);

        hpfs_slow_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_slow (oc_slow[g]),
            .expired (filt_done[g])
        );

        hpfs_slot_status u_status (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_en    (slot_en[g]),
            .rail_uv    (rail_uv[g]),
            .oc_fast    (oc_fast[g]),
            .oc_slow_ok (soc_ok[g]),
            .clr        (slot_clr[g]),
            .fault_q    (slot_flt[g])
        );
    end

    always_comb begin
        cs_hit = reg_wr && (reg_addr == ADDR_CS);
        cs_set = {|(stby_uv & slot_en), die_hot} & {2{|slot_en}};
        cs_clr = cs_hit ? {reg_wdata[CS_STBY], reg_wdata[CS_DIE]} : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_flt_q <= '0;
            mask_q   <= 1'b1;
        end else begin
            cs_flt_q <= cs_set | (cs_flt_q & ~cs_clr);
            if (cs_hit) mask_q <= reg_wdata[CS_MASK];
        end
    end

    assign any_fault = (|slot_flt) | (|cs_flt_q);

    hpfs_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_fault (any_fault),
        .mask      (mask_q),
        .irq_n     (irq_n)
    );

    always_comb begin
        reg_rdata = 8'h00;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (reg_addr == ADDR_W'(2 * s))
                reg_rdata = {6'b0, ctrl_q[s]};
            if (reg_addr == ADDR_W'(2 * s + 1))
                reg_rdata = {3'b0, slot_flt[s][2], 1'b0, slot_flt[s][1], 1'b0, slot_flt[s][0]};
        end
        if (reg_addr == ADDR_CS)
            reg_rdata = {2'b0, gpi, mask_q, cs_flt_q[1], cs_flt_q[0], 1'b0};
    end

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ctrl_q));

    // R7
    die_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (die_hot && (slot_en != '0)) |=> cs_flt_q[0]);

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(mask_q));
endmodule

// File: tb/hp_fault_status_test.sv
module hp_fault_status_test;
    localparam int FILT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] rail_uv = '0, stby_uv = '0, oc_fast = '0, oc_slow = '0, slot_hot = '0;
    logic       die_hot = 1'b0;
    logic [1:0] gpi = '0;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hp_fault_status #(.NUM_SLOTS(2), .FILT_CYCLES(FILT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rail_uv(rail_uv),
        .stby_uv(stby_uv), .oc_fast(oc_fast), .oc_slow(oc_slow),
        .slot_hot(slot_hot), .die_hot(die_hot), .gpi(gpi), .irq_n(irq_n)
    );

    // reference model built from the requirements
    logic [1:0] m_ctrl [2];
    logic [2:0] m_flt  [2];
    int         m_cnt  [2];
    logic [1:0] m_cs;
    logic       m_mask;
    logic       m_irq;

    always @(posedge clk or negedge rst_n) begin
        logic [1:0] nctrl [2];
        logic [2:0] nflt  [2];
        int         ncnt  [2];
        logic [1:0] ncs;
        logic [1:0] cset;
        logic [1:0] cclr;
        logic       nirq, anyen, sen, q;
        logic [2:0] sclr;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_ctrl[s] = '0; m_flt[s] = '0; m_cnt[s] = 0;
            end
            m_cs = '0; m_mask = 1'b1; m_irq = 1'b0;
        end else begin
            nirq  = ((m_flt[0] != 0) || (m_flt[1] != 0) || (m_cs != 0)) && !m_mask;
            anyen = (m_ctrl[0] != 0) || (m_ctrl[1] != 0);
            for (int s = 0; s < 2; s++) begin
                sen  = (m_ctrl[s] != 0);
                q    = oc_slow[s] && ((m_cnt[s] == FILT) || slot_hot[s]);
                sclr = (reg_wr && reg_addr == 3'(2 * s + 1)) ? {reg_wdata[4], reg_wdata[2], reg_wdata[0]} : 3'b0;
                nflt[s]  = ({q, oc_fast[s], rail_uv[s]} & {3{sen}}) | (m_flt[s] & ~sclr);
                ncnt[s]  = !oc_slow[s] ? 0 : ((m_cnt[s] < FILT) ? m_cnt[s] + 1 : m_cnt[s]);
                nctrl[s] = (reg_wr && reg_addr == 3'(2 * s)) ? reg_wdata[1:0] : m_ctrl[s];
            end
            cset = {((stby_uv[0] && m_ctrl[0] != 0) || (stby_uv[1] && m_ctrl[1] != 0)), die_hot} & {2{anyen}};
            cclr = (reg_wr && reg_addr == 3'd4) ? {reg_wdata[2], reg_wdata[1]} : 2'b0;
            ncs  = cset | (m_cs & ~cclr);
            if (reg_wr && reg_addr == 3'd4) m_mask = reg_wdata[3];
            for (int s = 0; s < 2; s++) begin
                m_ctrl[s] = nctrl[s]; m_flt[s] = nflt[s]; m_cnt[s] = ncnt[s];
            end
            m_cs = ncs; m_irq = nirq;
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {6'b0, m_ctrl[0]};
            3'd1: return {3'b0, m_flt[0][2], 1'b0, m_flt[0][1], 1'b0, m_flt[0][0]};
            3'd2: return {6'b0, m_ctrl[1]};
            3'd3: return {3'b0, m_flt[1][2], 1'b0, m_flt[1][1], 1'b0, m_flt[1][0]};
            3'd4: return {2'b0, gpi, m_mask, m_cs[1], m_cs[0], 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        if (a == 3'd1 || a == 3'd3) return "R8";
        if (a == 3'd4) return "R7";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
        chk("R10", {7'b0, irq_n}, {7'b0, ~m_irq});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_addr = 3'd4; step();
        chk("R1", reg_rdata, 8'h08);
        chk("R1", {7'b0, irq_n}, 8'h01);
        reg_addr = 3'd1; step();
        chk("R1", reg_rdata, 8'h00);

        // R3 fault on a disabled slot is not latched
        rail_uv[0] = 1'b1; step(); step();
        chk("R3", reg_rdata, 8'h00);
        rail_uv[0] = 1'b0;

        // R4 undervoltage and fast overcurrent
        wr(3'd0, 8'h01);
        reg_addr = 3'd1; oc_fast[0] = 1'b1; step();
        chk("R4", reg_rdata, 8'h04);
        oc_fast[0] = 1'b0; rail_uv[0] = 1'b1; step();
        chk("R4", reg_rdata, 8'h05);
        rail_uv[0] = 1'b0;

        // R11 repeated reads change nothing
        step(); step();
        chk("R11", reg_rdata, 8'h05);
        reg_addr = 3'd0; step();
        chk("R11", reg_rdata, 8'h01);

        // R8 write-0 keeps, write-1 clears
        wr(3'd1, 8'h00);
        chk("R8", reg_rdata, 8'h05);
        wr(3'd1, 8'h04);
        chk("R8", reg_rdata, 8'h01);

        // R9 set wins over clear, then relatch stops when condition goes
        rail_uv[0] = 1'b1;
        wr(3'd1, 8'h01);
        chk("R9", reg_rdata, 8'h01);
        rail_uv[0] = 1'b0;
        wr(3'd1, 8'h01);
        chk("R9", reg_rdata, 8'h00);

        // R10 interrupt follows latched faults and mask
        oc_fast[0] = 1'b1; step(); oc_fast[0] = 1'b0;
        step();
        chk("R10", {7'b0, irq_n}, 8'h01);
        wr(3'd4, 8'h00);
        step();
        chk("R10", {7'b0, irq_n}, 8'h00);
        wr(3'd1, 8'h04);
        step();
        chk("R10", {7'b0, irq_n}, 8'h01);

        // R5 slow overcurrent filter window
        wr(3'd2, 8'h02);
        reg_addr = 3'd3; oc_slow[1] = 1'b1;
        repeat (FILT) step();
        chk("R5", reg_rdata, 8'h00);
        step();
        chk("R5", reg_rdata, 8'h10);
        oc_slow[1] = 1'b0;
        wr(3'd3, 8'h10);
        chk("R5", reg_rdata, 8'h00);

        // R6 slow overcurrent with slot overtemperature bypasses the window
        oc_slow[1] = 1'b1; slot_hot[1] = 1'b1; step();
        chk("R6", reg_rdata, 8'h10);
        oc_slow[1] = 1'b0; slot_hot[1] = 1'b0;
        wr(3'd3, 8'h10);

        // R7 shared flags
        reg_addr = 3'd4; die_hot = 1'b1; step(); die_hot = 1'b0;
        chk("R7", reg_rdata, 8'h02);
        stby_uv[1] = 1'b1; step(); stby_uv[1] = 1'b0;
        chk("R7", reg_rdata, 8'h06);
        wr(3'd4, 8'h0E);
        chk("R8", reg_rdata, 8'h08);

        // R2 general-purpose inputs and unused address
        gpi = 2'b10; step();
        chk("R2", reg_rdata, 8'h28);
        gpi = 2'b00;
        reg_addr = 3'd6; step();
        chk("R2", reg_rdata, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            rail_uv  = {($urandom % 16) == 0, ($urandom % 16) == 0};
            stby_uv  = {($urandom % 32) == 0, ($urandom % 32) == 0};
            oc_fast  = {($urandom % 16) == 0, ($urandom % 16) == 0};
            for (int s = 0; s < 2; s++)
                if (($urandom % 8) == 0) oc_slow[s] = ~oc_slow[s];
            slot_hot = {($urandom % 8) == 0, ($urandom % 8) == 0};
            die_hot  = ($urandom % 32) == 0;
            gpi      = 2'($urandom);
            reg_addr = 3'($urandom % 6);
            reg_wr   = ($urandom % 3) == 0;
            reg_wdata = 8'($urandom);
            step();
        end
        reg_wr = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule